// File: doc/BRIEF.md
# Masked Packed SIMD Integer ALU

This block performs one lane-wise integer operation on a 256-bit vector operand pair. A type code splits the vector into equal two's-complement lanes of 8, 16, 32 or 64 bits. Five operations write data lanes: add, subtract, XOR, AND and OR. Three classification operations leave the data alone and raise one flag bit per lane when the lane of operand A is positive, zero or negative.

Operand A doubles as the destination's old contents, as in a two-address form: `dst = dst op src`. When the mask-enable input is set, only lanes whose bit in the mask word is 1 take part. Every other lane passes operand A through unchanged and gets no write enable and no flag.

The write enables come out at byte granularity, so a register file can use them whatever the lane width. All outputs are registered one cycle after an input strobe.

Top module: `simd_lane_alu`

## Requirements
- R1: Type code 3'b000, 3'b001, 3'b010 and 3'b011 select 8-, 16-, 32- and 64-bit lanes, giving 32, 16, 8 and 4 lanes. Lane i occupies bits [i*W +: W].
- R2: Opcode 6'o04 (add) and 6'o05 (subtract, A minus B) give A op B per lane, wrapped modulo 2^W. No carry or borrow crosses a lane boundary.
- R3: Opcode 6'o13 gives XOR, 6'o14 gives AND and 6'o15 gives OR of A and B, applied bitwise per lane.
- R4: Opcode 6'o10, 6'o11 and 6'o12 set flag bit i when lane i of A is positive (nonzero with the sign bit clear), zero, or negative (sign bit set) respectively. Operand B is ignored.
- R5: A classification operation leaves the result equal to A and all write enables clear. Its flag bits at and above the lane count are 0.
- R6: With mask_en = 1, lane i is operated on only when mask_word[i] = 1. Any other lane outputs its A value, has clear write enables and a 0 flag. With mask_en = 0, every lane is operated on.
- R7: Write-enable bit k (byte k of the vector) is set exactly when a data-writing operation (R2, R3) writes the lane that contains byte k.
- R8: A data-writing operation returns an all-zero flag word.
- R9: An opcode outside the eight listed above, or a type code with bit 2 set, returns result = A, write enables 0 and flags 0.
- R10: Outputs load on the clock edge that samples in_valid = 1, and out_valid is high for exactly that following cycle. Without a strobe the outputs hold. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| opa | input | 256 | Operand A / old destination contents |
| opb | input | 256 | Operand B |
| op_code | input | 6 | Operation code |
| lane_type | input | 3 | Lane width code |
| mask_en | input | 1 | Enable the lane mask |
| mask_word | input | 32 | Lane mask, bit i for lane i |
| out_valid | output | 1 | Result valid |
| out_result | output | 256 | Result vector |
| out_we | output | 32 | Per-byte write enables |
| out_flags | output | 32 | Per-lane classification flags |

## Verification
The bench builds the block with the default vector width of 256 bits. At that width all four lane counts are reachable, from 4 long lanes up to 32 byte lanes. In byte mode every bit of the mask word and of the flag word is in use, so the case of an unused upper flag field and the case of a completely full one can both be checked. A mixed-content operand holds zero lanes, minimum negatives, maximum positives and ones. With it, each classification at each width meets all three outcomes, and carries at the byte-to-halfword boundary show whether lanes stay isolated.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [5:0] {
    OP_ADD = 6'o04,
    OP_SUB = 6'o05,
    OP_POS = 6'o10,
    OP_ZER = 6'o11,
    OP_NEG = 6'o12,
    OP_XOR = 6'o13,
    OP_AND = 6'o14,
    OP_OR  = 6'o15
  } op_e;

  typedef enum logic [2:0] {
    LT_BYTE = 3'd0,
    LT_HALF = 3'd1,
    LT_WORD = 3'd2,
    LT_LONG = 3'd3
  } lane_type_e;

  function automatic logic op_writes(input logic [5:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_XOR) ||
           (op == OP_AND) || (op == OP_OR);
  endfunction

  function automatic logic op_classifies(input logic [5:0] op);
    return (op == OP_POS) || (op == OP_ZER) || (op == OP_NEG);
  endfunction

endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [5:0]   op,
  output logic [W-1:0] res,
  output logic         is_pos,
  output logic         is_zero,
  output logic         is_neg
);

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_XOR:  res = a ^ b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      default: res = a;
    endcase
  end

  assign is_neg  = a[W-1];
  assign is_zero = (a == '0);
  assign is_pos  = !is_neg && !is_zero;

endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group #(
  parameter int W     = 8,
  parameter int VEC_W = 256,
  localparam int N    = VEC_W / W
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [5:0]       op,
  output logic [VEC_W-1:0] res,
  output logic [N-1:0]     pos,
  output logic [N-1:0]     zero,
  output logic [N-1:0]     neg
);

  for (genvar g = 0; g < N; g++) begin : g_lane
    simd_lane_op #(.W(W)) u_op (
      .a       (a[g*W +: W]),
      .b       (b[g*W +: W]),
      .op      (op),
      .res     (res[g*W +: W]),
      .is_pos  (pos[g]),
      .is_zero (zero[g]),
      .is_neg  (neg[g])
    );
  end

endmodule

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl #(
  parameter int VEC_W = 256,
  localparam int MAXL = VEC_W / 8
) (
  input  logic [2:0]      lane_type,
  input  logic            mask_en,
  input  logic [MAXL-1:0] mask_word,
  output logic [MAXL-1:0] lane_on,
  output logic [MAXL-1:0] byte_en
);

  logic [MAXL-1:0] present;

  always_comb begin
    for (int i = 0; i < MAXL; i++) begin
      present[i] = (i < (MAXL >> lane_type[1:0]));
    end
  end

  assign lane_on = present & (mask_en ? mask_word : {MAXL{1'b1}});

  always_comb begin
    for (int k = 0; k < MAXL; k++) begin
      byte_en[k] = lane_on[k >> lane_type[1:0]];
    end
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int VEC_W = 256,
  localparam int MAXL = VEC_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic [5:0]       op_code,
  input  logic [2:0]       lane_type,
  input  logic             mask_en,
  input  logic [MAXL-1:0]  mask_word,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result,
  output logic [MAXL-1:0]  out_we,
  output logic [MAXL-1:0]  out_flags
);

  logic [VEC_W-1:0] grp_res  [4];
  logic [MAXL-1:0]  grp_pos  [4];
  logic [MAXL-1:0]  grp_zero [4];
  logic [MAXL-1:0]  grp_neg  [4];

  for (genvar t = 0; t < 4; t++) begin : g_width
    localparam int W = 8 << t;
    localparam int N = VEC_W / W;
    logic [N-1:0] p_w, z_w, n_w;

    simd_lane_group #(.W(W), .VEC_W(VEC_W)) u_grp (
      .a    (opa),
      .b    (opb),
      .op   (op_code),
      .res  (grp_res[t]),
      .pos  (p_w),
      .zero (z_w),
      .neg  (n_w)
    );

    assign grp_pos[t]  = MAXL'(p_w);
    assign grp_zero[t] = MAXL'(z_w);
    assign grp_neg[t]  = MAXL'(n_w);
  end

  logic [MAXL-1:0] lane_on, byte_en;

  simd_lane_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .lane_type (lane_type),
    .mask_en   (mask_en),
    .mask_word (mask_word),
    .lane_on   (lane_on),
    .byte_en   (byte_en)
  );

  // Named decode events, also observed by the checker
  logic type_ok, wr_ok, cmp_ok;
  assign type_ok = !lane_type[2];
  assign wr_ok   = type_ok && op_writes(op_code);
  assign cmp_ok  = type_ok && op_classifies(op_code);

  logic [VEC_W-1:0] sel_res;
  logic [MAXL-1:0]  sel_class;

  always_comb begin
    sel_res = grp_res[lane_type[1:0]];
    case (op_code)
      OP_POS:  sel_class = grp_pos[lane_type[1:0]];
      OP_ZER:  sel_class = grp_zero[lane_type[1:0]];
      default: sel_class = grp_neg[lane_type[1:0]];
    endcase
  end

  logic [MAXL-1:0]  nxt_we, nxt_flags;
  logic [VEC_W-1:0] nxt_res;

  assign nxt_we    = wr_ok  ? byte_en : '0;
  assign nxt_flags = cmp_ok ? (sel_class & lane_on) : '0;

  always_comb begin
    for (int k = 0; k < MAXL; k++) begin
      nxt_res[k*8 +: 8] = nxt_we[k] ? sel_res[k*8 +: 8] : opa[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_we     <= '0;
      out_flags  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_res;
        out_we     <= nxt_we;
        out_flags  <= nxt_flags;
      end
    end
  end

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int VEC_W = 256,
  localparam int MAXL = VEC_W / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [VEC_W-1:0] opa,
  input logic [2:0]       lane_type,
  input logic             mask_en,
  input logic [MAXL-1:0]  mask_word,
  input logic             wr_ok,
  input logic             cmp_ok,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_result,
  input logic [MAXL-1:0]  out_we,
  input logic [MAXL-1:0]  out_flags
);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_we) && $stable(out_flags)));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_we == '0 || out_flags == '0));

  assert_cmp_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_ok) |=> (out_we == '0 && out_result == $past(opa)));

  assert_upper_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_type == 3'd3) |=> (out_flags[MAXL-1:4] == '0));

  assert_mask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && mask_word == '0) |=>
      (out_we == '0 && out_flags == '0 && out_result == $past(opa)));

  assert_bad_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_type[2]) |=>
      (out_we == '0 && out_flags == '0 && out_result == $past(opa)));

  assert_long_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wr_ok && lane_type == 3'd3) |=>
      (out_we[7:0] == 8'h00 || out_we[7:0] == 8'hFF));

endmodule

bind simd_lane_alu simd_lane_alu_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .opa        (opa),
  .lane_type  (lane_type),
  .mask_en    (mask_en),
  .mask_word  (mask_word),
  .wr_ok      (wr_ok),
  .cmp_ok     (cmp_ok),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_we     (out_we),
  .out_flags  (out_flags)
);

// File: tb/test_simd_lane_alu.sv
`timescale 1ns/1ps
module test_simd_lane_alu;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] opa = '0, opb = '0;
  logic [5:0]   op_code = '0;
  logic [2:0]   lane_type = '0;
  logic         mask_en = 1'b0;
  logic [31:0]  mask_word = '0;
  logic         out_valid;
  logic [255:0] out_result;
  logic [31:0]  out_we, out_flags;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  simd_lane_alu i_simd_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .op_code(op_code), .lane_type(lane_type), .mask_en(mask_en),
    .mask_word(mask_word), .out_valid(out_valid), .out_result(out_result),
    .out_we(out_we), .out_flags(out_flags)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [2:0]  typ;
    logic        men;
    logic [31:0] mask;
    logic [31:0] sa;
    logic [31:0] sb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TABLE [NV] = '{
    '{6'o04, 3'd0, 1'b0, 32'h0,         32'd11, 32'd22},  // R1 R2 byte add
    '{6'o04, 3'd1, 1'b1, 32'h0000_A5C3, 32'd13, 32'd24},  // R6 masked halfword add
    '{6'o05, 3'd2, 1'b0, 32'h0,         32'd33, 32'd44},  // R2 word subtract
    '{6'o05, 3'd3, 1'b0, 32'h0,         32'd0,  32'd1},   // R2 0 - (-1) per long lane
    '{6'o13, 3'd0, 1'b0, 32'h0,         32'd55, 32'd66},  // R3 xor
    '{6'o14, 3'd1, 1'b1, 32'hFFFF_0000, 32'd57, 32'd68},  // R6 mask only beyond lane count
    '{6'o15, 3'd3, 1'b0, 32'h0,         32'd77, 32'd88},  // R3 or
    '{6'o10, 3'd0, 1'b0, 32'h0,         32'd2,  32'd99},  // R4 positive bytes
    '{6'o11, 3'd1, 1'b0, 32'h0,         32'd2,  32'd98},  // R4 zero halfwords
    '{6'o12, 3'd2, 1'b0, 32'h0,         32'd2,  32'd97},  // R4 negative words
    '{6'o10, 3'd3, 1'b1, 32'h0000_0005, 32'd2,  32'd96},  // R6 masked compare
    '{6'o11, 3'd0, 1'b1, 32'hF0F0_F0F0, 32'd2,  32'd95},  // R6 masked zero bytes
    '{6'o06, 3'd1, 1'b0, 32'h0,         32'd21, 32'd31},  // R9 unknown opcode
    '{6'o04, 3'd4, 1'b0, 32'h0,         32'd23, 32'd34},  // R9 unsupported type
    '{6'o04, 3'd0, 1'b1, 32'hFFFF_FFFF, 32'd1,  32'd1}    // R6 full byte mask
  };

  function automatic logic [255:0] gen(input logic [31:0] s);
    logic [31:0]  x;
    logic [255:0] g;
    if (s == 0) return '0;
    if (s == 1) return '1;
    if (s == 2) return {64'h0000_0000_0000_0000, 64'h8000_0000_0000_0001,
                        64'h0000_7FFF_0000_8000, 64'h00FF_0080_007F_0000};
    x = s;
    for (int k = 0; k < 8; k++) begin
      x = x * 32'h0019_660D + 32'h3C6E_F35F;
      g[k*32 +: 32] = x ^ {x[15:0], x[31:16]};
    end
    return g;
  endfunction

  // Independent reference: lanes pulled out by shifting the whole vector
  task automatic model(input logic [5:0] op, input logic [2:0] typ, input logic men,
                       input logic [31:0] mask, input logic [255:0] a, input logic [255:0] b,
                       output logic [255:0] r, output logic [31:0] we, output logic [31:0] fl);
    int w, n;
    logic wr, cl, on, ng, zr;
    logic [255:0] lm, la, lb, lr;
    r = a; we = '0; fl = '0;
    wr = (op == 6'o04) || (op == 6'o05) || (op == 6'o13) || (op == 6'o14) || (op == 6'o15);
    cl = (op == 6'o10) || (op == 6'o11) || (op == 6'o12);
    if (typ > 3'd3 || !(wr || cl)) return;
    w  = 8 << typ;
    n  = 256 / w;
    lm = (256'd1 << w) - 256'd1;
    for (int i = 0; i < n; i++) begin
      on = !men || mask[i];
      la = (a >> (i * w)) & lm;
      lb = (b >> (i * w)) & lm;
      if (wr && on) begin
        case (op)
          6'o04:   lr = la + lb;
          6'o05:   lr = la - lb;
          6'o13:   lr = la ^ lb;
          6'o14:   lr = la & lb;
          default: lr = la | lb;
        endcase
        lr = lr & lm;
        r  = (r & ~(lm << (i * w))) | (lr << (i * w));
        for (int j = 0; j < w / 8; j++) we[i * (w / 8) + j] = 1'b1;
      end
      if (cl && on) begin
        ng = la[w-1];
        zr = (la == '0);
        if (op == 6'o10)      fl[i] = !ng && !zr;
        else if (op == 6'o11) fl[i] = zr;
        else                  fl[i] = ng;
      end
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [2:0] typ, input logic men,
                       input logic [31:0] mask, input logic [255:0] a, input logic [255:0] b);
    @(negedge clk);
    op_code = op; lane_type = typ; mask_en = men; mask_word = mask;
    opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string req_of(input logic [5:0] op, input logic [2:0] typ, input logic men);
    if (typ[2]) return "R9";
    if (men) return "R6";
    case (op)
      6'o04, 6'o05:        return "R2";
      6'o13, 6'o14, 6'o15: return "R3";
      6'o10, 6'o11, 6'o12: return "R4";
      default:             return "R9";
    endcase
  endfunction

  initial begin
    #200000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [255:0] er, a, b;
    logic [31:0]  ew, ef;

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10", "reset valid", 256'(out_valid), 256'd0);
    check("R10", "reset result", out_result, '0);
    check("R10", "reset we/flags", {out_we, out_flags}, '0);
    rst_n = 1'b1;

    foreach (TABLE[v]) begin
      a = gen(TABLE[v].sa);
      b = gen(TABLE[v].sb);
      model(TABLE[v].op, TABLE[v].typ, TABLE[v].men, TABLE[v].mask, a, b, er, ew, ef);
      apply(TABLE[v].op, TABLE[v].typ, TABLE[v].men, TABLE[v].mask, a, b);
      check("R10", "valid", 256'(out_valid), 256'd1);
      check(req_of(TABLE[v].op, TABLE[v].typ, TABLE[v].men), "result", out_result, er);
      check("R7", "write enables", 256'(out_we), 256'(ew));
      check("R5", "flags", 256'(out_flags), 256'(ef));  // R8 zero flags for writes
    end

    // R10 hold: no strobe, outputs keep last values
    er = out_result;
    @(negedge clk);
    check("R10", "valid after idle", 256'(out_valid), 256'd0);
    check("R10", "held result", out_result, er);

    // R2 carry stays in lane: byte vs halfword on the same data
    apply(6'o04, 3'd0, 1'b0, 32'h0, {16{16'h00FF}}, {16{16'h0001}});
    check("R2", "byte add no cross carry", out_result, '0);
    apply(6'o04, 3'd1, 1'b0, 32'h0, {16{16'h00FF}}, {16{16'h0001}});
    check("R2", "halfword add inner carry", out_result, {16{16'h0100}});
    apply(6'o05, 3'd0, 1'b0, 32'h0, '0, {32{8'h01}});
    check("R2", "byte subtract wrap", out_result, {32{8'hFF}});

    // R4 byte extremes: 0x80 negative, 0x7F positive, 0x00 zero
    apply(6'o12, 3'd0, 1'b0, 32'h0, {240'd0, 16'h807F}, '1);
    check("R4", "negative min byte", 256'(out_flags), 256'(32'h0000_0002));
    apply(6'o10, 3'd0, 1'b0, 32'h0, {240'd0, 16'h807F}, '1);
    check("R4", "positive max byte", 256'(out_flags), 256'(32'h0000_0001));
    apply(6'o11, 3'd0, 1'b0, 32'h0, {240'd0, 16'h807F}, '1);
    check("R4", "zero bytes", 256'(out_flags), 256'(32'hFFFF_FFFC));

    // R5 long-lane zero compare leaves upper flag bits clear
    apply(6'o11, 3'd3, 1'b0, 32'h0, '0, '0);
    check("R5", "long zero flags", 256'(out_flags), 256'(32'h0000_000F));
    check("R5", "compare result passthru", out_result, '0);

    // R1 R7 word lane 7 only, byte enables 28..31
    apply(6'o15, 3'd2, 1'b1, 32'h0000_0080, '0, '1);
    check("R1", "top word lane", out_result, {32'hFFFF_FFFF, 224'd0});
    check("R7", "top word enables", 256'(out_we), 256'(32'hF000_0000));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule